// File: doc/BRIEF.md
# Module Power Gating Wake Controller

This block sits on a 16-bit register bus and decides which on-chip modules are powered down. Software sets one shutdown bit per module position. Each bit drives an active-high gate output that the power switches use to cut that module off. Eight wake sources each have their own recovery mask with one bit per module. When a source shows a rising edge, the controller clears the shutdown bit of every module whose bit is set in that source's mask. This brings the modules back without software help. A breakpoint event works the other way round: it wakes every shut-down module that is not listed in a per-module breakpoint mask.

The same register space also holds a clock divide field and a PLL bypass bit. Both leave the block as plain configuration outputs. Registers are halfword aligned and are addressed by byte offset. Writes take effect on the clock edge on which `busWrite` is high. Reads are combinational from `busAddr`.

Module positions are shared by every mask: 0 core, 1 DMA, 2 serial I/O, 3 glue logic, 4 host port, 5 AHB master, 7 on-chip emulation, 8 timer 0, 9 timer 1, 10 JAM. Positions 6 and 11 to 15 are reserved. Wake source index k has its recovery mask at offset 0x88 + 2k, in this order: 0 interrupt 0, 1 interrupt 1, 2 interrupt 2, 3 vectored interrupt, 4 timer 0, 5 timer 1, 6 non-maskable interrupt, 7 external signal.

Top module: `pgw_top`

## Requirements
- R1: After reset, every shutdown bit, recovery mask, breakpoint mask, divide field and the bypass bit read 0, and all gate outputs are 0.
- R2: A write to offset 0x86 loads the shutdown bits on that clock edge, keeping only module positions 0-5 and 7-10. The register reads back the stored value, and `gateOut` equals the stored value from the following cycle on. Reserved positions are always 0.
- R3: The recovery masks at 0x88 to 0x94 (sources 0 to 6) store and read back the module positions 0-5 and 7-10.
- R4: The timer 0 source mask (0x90) has no bit 8, and the timer 1 source mask (0x92) has no bit 9. Those positions read 0 and ignore writes.
- R5: The external-signal source mask at 0x96 keeps only bit 1 (DMA).
- R6: The breakpoint mask at 0x98 keeps only bits 1, 8 and 9.
- R7: On the clock edge where a wake input is high and was low at the previous edge, every shutdown bit set in that source's mask is cleared. A wake input that stays high causes no further clearing.
- R8: When a shutdown write and a wake edge fall on the same clock edge, the written value is stored with the woken bits cleared.
- R9: On a rising edge of `brkIn`, each shutdown bit whose breakpoint mask bit is 0 is cleared. Bits whose mask bit is 1 keep their value.
- R10: Offset 0x84 holds the divide field in bits DIV_W-1:0 and the PLL bypass in bit 15 (1 = bypass). `clkDiv` equals the field, except that a field of 0 or 1 gives 1. `pllBypass` follows bit 15.
- R11: Odd addresses, and offsets not listed above, read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrite | input | 1 | Write strobe, taken on the rising clock edge |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| wakeIn | input | 8 | Wake sources, index k as listed above |
| brkIn | input | 1 | Breakpoint event |
| gateOut | output | 16 | Per-module power-down gate, 1 = module off |
| clkDiv | output | DIV_W | Effective clock divide ratio |
| pllBypass | output | 1 | PLL bypass select |

## Verification
The assertions assume that the wake and breakpoint inputs are synchronous to `clk` and held low while reset is active. Under that assumption, the first edge after reset never reports a rising edge that was not seen. They also assume that `busWdata` is stable around the edge on which a write is taken. The bench changes every input only on the falling clock edge and keeps all event inputs low during reset. It raises each event for at least one full cycle, so every edge the controller sees is a clean, single-cycle rising edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int NSRC   = 8;

  localparam logic [ADDR_W-1:0] OFS_CLK  = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_SD   = 8'h86;
  localparam logic [ADDR_W-1:0] OFS_REC0 = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_BP   = 8'h98;

  localparam logic [DATA_W-1:0] MOD_IMPL = 16'h07BF;
  localparam logic [DATA_W-1:0] EXT_IMPL = 16'h0002;
  localparam logic [DATA_W-1:0] BP_IMPL  = 16'h0302;

  localparam int T0_SRC  = 4;
  localparam int T1_SRC  = 5;
  localparam int EXT_SRC = 7;
  localparam int T0_BIT  = 8;
  localparam int T1_BIT  = 9;
  localparam int BYP_BIT = 15;

  // bits a recovery mask of source k can hold
  function automatic logic [DATA_W-1:0] recImpl(int k);
    logic [DATA_W-1:0] m;
    m = MOD_IMPL;
    if (k == EXT_SRC) m = EXT_IMPL;
    if (k == T0_SRC)  m[T0_BIT] = 1'b0;
    if (k == T1_SRC)  m[T1_BIT] = 1'b0;
    return m;
  endfunction

  typedef struct packed {
    logic            wrEn;
    logic            selClk;
    logic            selSd;
    logic [NSRC-1:0] selRec;
    logic            selBp;
    logic [NSRC-1:0] wakeRose;
    logic            brkRose;
  } ctrlStrobe_t;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [NSRC-1:0]   wakeIn,
  input  logic              brkIn,
  output ctrlStrobe_t       st
);
  logic [NSRC-1:0] wakePrev;
  logic            brkPrev;
  logic            aligned;

  assign aligned = ~busAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePrev <= '0;
      brkPrev  <= 1'b0;
    end else begin
      wakePrev <= wakeIn;
      brkPrev  <= brkIn;
    end
  end

  always_comb begin
    st          = '0;
    st.wrEn     = busWrite;
    st.selClk   = aligned && (busAddr == OFS_CLK);
    st.selSd    = aligned && (busAddr == OFS_SD);
    st.selBp    = aligned && (busAddr == OFS_BP);
    for (int k = 0; k < NSRC; k++) begin
      st.selRec[k] = aligned && (busAddr == ADDR_W'(OFS_REC0 + 2 * k));
    end
    st.wakeRose = wakeIn & ~wakePrev;
    st.brkRose  = brkIn & ~brkPrev;
  end
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] gateOut,
  output logic [DIV_W-1:0]  clkDiv,
  output logic              pllBypass
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DATA_W-1:0] sdReg;
  logic [DATA_W-1:0] recMask [NSRC];
  logic [DATA_W-1:0] bpMask;
  logic [DIV_W-1:0]  divField;
  logic              bypassReg;
  logic [DATA_W-1:0] wakeClr;
  logic [DATA_W-1:0] sdNext;

  // per-source recovery masks
  for (genvar k = 0; k < NSRC; k++) begin : g_rec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        recMask[k] <= '0;
      else if (st.wrEn && st.selRec[k]) recMask[k] <= busWdata & recImpl(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpMask    <= '0;
      divField  <= '0;
      bypassReg <= 1'b0;
    end else begin
      if (st.wrEn && st.selBp) bpMask <= busWdata & BP_IMPL;
      if (st.wrEn && st.selClk) begin
        divField  <= busWdata[DIV_W-1:0];
        bypassReg <= busWdata[BYP_BIT];
      end
    end
  end

  // wake and breakpoint clear vector; wins over a same-cycle write
  always_comb begin
    wakeClr = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (st.wakeRose[k]) wakeClr = wakeClr | recMask[k];
    end
    if (st.brkRose) wakeClr = wakeClr | (MOD_IMPL & ~bpMask);
    sdNext = (st.wrEn && st.selSd) ? (busWdata & MOD_IMPL) : sdReg;
    sdNext = sdNext & ~wakeClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdReg <= '0;
    else       sdReg <= sdNext;
  end

  assign gateOut   = sdReg;
  assign clkDiv    = (divField <= DIV_ONE) ? DIV_ONE : divField;
  assign pllBypass = bypassReg;

  always_comb begin
    busRdata = '0;
    if (st.selSd) busRdata = sdReg;
    if (st.selBp) busRdata = bpMask;
    if (st.selClk) begin
      busRdata[DIV_W-1:0] = divField;
      busRdata[BYP_BIT]   = bypassReg;
    end
    for (int k = 0; k < NSRC; k++) begin
      if (st.selRec[k]) busRdata = recMask[k];
    end
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrite,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic [7:0]        wakeIn,
  input  logic              brkIn,
  output logic [15:0]       gateOut,
  output logic [DIV_W-1:0]  clkDiv,
  output logic              pllBypass
);
  ctrlStrobe_t st;

  pgw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .wakeIn   (wakeIn),
    .brkIn    (brkIn),
    .st       (st)
  );

  pgw_datapath #(.DIV_W(DIV_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .gateOut   (gateOut),
    .clkDiv    (clkDiv),
    .pllBypass (pllBypass)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
  import pgw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input ctrlStrobe_t       st,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] gateOut,
  input logic [DIV_W-1:0]  clkDiv
);
  p_gate_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut & ~MOD_IMPL) == '0);

  p_plain_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.selSd && st.wakeRose == '0 && !st.brkRose)
      |=> gateOut == $past(busWdata & MOD_IMPL));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(st.wrEn && st.selSd) && st.wakeRose == '0 && !st.brkRose)
      |=> $stable(gateOut));

  p_wake_never_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((st.wakeRose != '0 || st.brkRose) && !(st.wrEn && st.selSd))
      |=> (gateOut & ~$past(gateOut)) == '0);

  p_div_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    clkDiv != '0);
endmodule

bind pgw_top pgw_checker #(.DIV_W(DIV_W)) u_pgw_checker (
  .clk      (clk),
  .rstN     (rstN),
  .st       (st),
  .busWdata (busWdata),
  .gateOut  (gateOut),
  .clkDiv   (clkDiv)
);

// File: tb/test_pgw_top.sv
`timescale 1ns/1ps
module test_pgw_top;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       busAddr = '0;
  logic             busWrite = 1'b0;
  logic [15:0]      busWdata = '0;
  logic [15:0]      busRdata;
  logic [7:0]       wakeIn = '0;
  logic             brkIn = 1'b0;
  logic [15:0]      gateOut;
  logic [DIV_W-1:0] clkDiv;
  logic             pllBypass;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pgw_top #(.DIV_W(DIV_W)) i_pgw_top (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk); #1;
    busWrite = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; #1;
    d = busRdata;
  endtask

  task automatic wakePulse(int k);
    @(negedge clk); wakeIn[k] = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); wakeIn[k] = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 gate", gateOut, 0);
    rd(8'h86, d); chk("R1 shutdown", d, 0);
    rd(8'h90, d); chk("R1 recovery", d, 0);
    rd(8'h98, d); chk("R1 bp mask", d, 0);
    rd(8'h84, d); chk("R1 clk cfg", d, 0);
    chk("R1 bypass", pllBypass, 0);
  endtask

  task automatic t_shutdown();
    logic [15:0] d;
    wr(8'h86, 16'hFFFF);
    chk("R2 gate", gateOut, 16'h07BF);
    rd(8'h86, d); chk("R2 readback", d, 16'h07BF);
    wr(8'h86, 16'h0041);
    chk("R2 gate pattern", gateOut, 16'h0001);
  endtask

  task automatic t_masks();
    logic [15:0] d;
    logic [15:0] exp [8] = '{16'h07BF, 16'h07BF, 16'h07BF, 16'h07BF,
                             16'h06BF, 16'h05BF, 16'h07BF, 16'h0002};
    for (int k = 0; k < 8; k++) begin
      wr(8'(8'h88 + 2 * k), 16'hFFFF);
      rd(8'(8'h88 + 2 * k), d);
      if (k == 4 || k == 5) chk("R4 timer self bit", d, exp[k]);
      else if (k == 7)      chk("R5 external mask", d, exp[k]);
      else                  chk("R3 recovery mask", d, exp[k]);
    end
    wr(8'h98, 16'hFFFF);
    rd(8'h98, d); chk("R6 bp mask", d, 16'h0302);
  endtask

  task automatic t_wake();
    wr(8'h88, 16'h0003);
    wr(8'h86, 16'h07BF);
    @(negedge clk); wakeIn[0] = 1'b1;
    @(posedge clk); #1;
    chk("R7 wake clears", gateOut, 16'h07BC);
    wr(8'h86, 16'h07BF);
    chk("R7 held level no reclear", gateOut, 16'h07BF);
    @(negedge clk); wakeIn[0] = 1'b0;
    wr(8'h8A, 16'h0000);
    wakePulse(1);
    chk("R7 empty mask", gateOut, 16'h07BF);
    wr(8'h90, 16'h0300);
    wakePulse(4);
    chk("R4 timer0 source", gateOut, 16'h05BF);
    wr(8'h86, 16'h07BF);
    wr(8'h96, 16'hFFFF);
    wakePulse(7);
    chk("R5 external source", gateOut, 16'h07BD);
  endtask

  task automatic t_collision();
    wr(8'h86, 16'h0000);
    wr(8'h8C, 16'h0010);
    @(negedge clk);
    busAddr = 8'h86; busWdata = 16'hFFFF; busWrite = 1'b1; wakeIn[2] = 1'b1;
    @(posedge clk); #1;
    busWrite = 1'b0;
    chk("R8 wake beats write", gateOut, 16'h07AF);
    @(negedge clk); wakeIn[2] = 1'b0;
  endtask

  task automatic t_brk();
    wr(8'h98, 16'hFFFF);
    wr(8'h86, 16'h07BF);
    @(negedge clk); brkIn = 1'b1;
    @(posedge clk); #1;
    chk("R9 bp masked kept", gateOut, 16'h0302);
    @(negedge clk); brkIn = 1'b0;
  endtask

  task automatic t_clk();
    logic [15:0] d;
    wr(8'h84, 16'hFF05);
    chk("R10 divide", clkDiv, 5);
    chk("R10 bypass", pllBypass, 1);
    rd(8'h84, d); chk("R10 readback", d, 16'h8005);
    wr(8'h84, 16'h0000);
    chk("R10 zero gives one", clkDiv, 1);
    chk("R10 bypass off", pllBypass, 0);
    wr(8'h84, 16'h0001);
    chk("R10 one gives one", clkDiv, 1);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    wr(8'h86, 16'h0005);
    wr(8'h87, 16'hFFFF);
    chk("R11 odd write ignored", gateOut, 16'h0005);
    rd(8'h87, d); chk("R11 odd reads zero", d, 0);
    wr(8'h9A, 16'hFFFF);
    rd(8'h9A, d); chk("R11 unlisted reads zero", d, 0);
    wr(8'h80, 16'hFFFF);
    rd(8'h80, d); chk("R11 low offset zero", d, 0);
    chk("R11 gate unchanged", gateOut, 16'h0005);
  endtask

  initial begin
    #100_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_shutdown();
    t_masks();
    t_wake();
    t_collision();
    t_brk();
    t_clk();
    t_unmapped();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule